// File: doc/BRIEF.md
# Multi-Bus Register Bank

This block is the programmer-visible and scratch register storage of a small microcoded 8-bit processor. It holds seven byte registers: two accumulators, a two-byte index register, a two-byte stack pointer and a hidden scratch register. Every write arrives on the single ALU result bus. An encoded load field, qualified by a load strobe, picks at most one destination, and that register captures on the rising clock edge. A copy from memory into a register is therefore an ALU pass (OR with zero), and the bank has no separate memory write path.

Two combinational read buses feed the ALU. The left bus is driven from an encoded 4-bit source field. Its sources are the bank registers, three pass-through bytes (program counter low and high, status) and the external data bus. The right bus is driven from a 2-bit field that can pick only the scratch register or the data bus. Every source field has a null code. A null or unused code leaves its bus idle at zero. The bank also produces the enable and direction controls for the two data-bus transceivers. A transceiver's direction follows whether its internal bus is reading the data bus, so two drivers can never meet on either side.

Top module: `rf_busbank`

## Requirements
- R1: With `load_en` high, load code 1..7 writes `alu_z` into exactly one register on the rising clock edge (1 = A, 2 = B, 3 = index low, 4 = index high, 5 = stack low, 6 = stack high, 7 = scratch). All other registers hold, and the new value shows on the buses in the cycle after the edge.
- R2: Load codes 0 and 8..15, or `load_en` low, change no register.
- R3: Left source codes select: 1 = A, 2 = B, 3 = index low, 4 = index high, 5 = `pc_lo`, 6 = `pc_hi`, 7 = stack low, 8 = stack high, 9 = `stat_in`, 10 = `dbus_in`. Code 10 yields `dbus_in` only while the left transceiver is enabled, and zero otherwise.
- R4: Left source code 0 and the unused codes 11..15 drive `left_bus` to all zeros.
- R5: Right source code 1 selects the scratch register. Code 2 selects `dbus_in` only while the right transceiver is enabled, and zero otherwise. Codes 0 and 3 give zero. No left code reads the scratch register.
- R6: Data-bus select `dsel` = 1 enables the left transceiver and 2 enables the right one. Codes 0 and 3 enable neither, and the two are never enabled together.
- R7: A transceiver points inward (`xl_in`/`xr_in` = 1) exactly when its bus source code picks the data bus (left 10, right 2). An enabled outward transceiver sets `dbus_oe` and puts its bus value on `dbus_out`. Otherwise `dbus_out` is zero and `dbus_oe` is low.
- R8: When the left code is 10 and the right code is 2 at once, `bus_err` is high. Both transceivers are then disabled, and both buses read zero from the data bus.
- R9: A synchronous active-high reset clears all seven registers to 0x00 and takes priority over a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Load strobe |
| load_sel | input | 4 | Encoded destination register |
| alu_z | input | DW | ALU result bus, sole write data |
| lsel | input | 4 | Left bus source code |
| rsel | input | 2 | Right bus source code |
| dsel | input | 2 | Data-bus transceiver select |
| pc_lo | input | DW | Program counter low byte, pass-through |
| pc_hi | input | DW | Program counter high byte, pass-through |
| stat_in | input | DW | Status byte, pass-through |
| dbus_in | input | DW | Value present on the external data bus |
| left_bus | output | DW | Left ALU operand bus |
| right_bus | output | DW | Right ALU operand bus |
| dbus_out | output | DW | Value driven toward the data bus |
| dbus_oe | output | 1 | Bank drives the data bus |
| xl_en | output | 1 | Left transceiver enable |
| xl_in | output | 1 | Left transceiver direction, 1 = inward |
| xr_en | output | 1 | Right transceiver enable |
| xr_in | output | 1 | Right transceiver direction, 1 = inward |
| bus_err | output | 1 | Both buses request the data bus |

## Verification
The hardest situations to reach are the ones where a select field is legal on its own but wrong in combination. Examples are a bus reading the data bus while the other transceiver is the one enabled, and both buses claiming the data bus at once. The stimulus therefore sweeps every combination of left, right and data-bus select after each phase of register contents. Those phases are: just after reset, after distinct writes to all seven registers, after loads with ignored codes, and after a reset that collides with a load. Every output is compared against a bench model in every combination.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
   localparam int LD_SEL_W = 4;
   localparam int L_SEL_W  = 4;
   localparam int R_SEL_W  = 2;
   localparam int D_SEL_W  = 2;
   localparam int NREG     = 7;

   // storage slots; load code k writes slot k-1
   localparam int RG_A   = 0;
   localparam int RG_B   = 1;
   localparam int RG_IXL = 2;
   localparam int RG_IXH = 3;
   localparam int RG_SPL = 4;
   localparam int RG_SPH = 5;
   localparam int RG_TMP = 6;

   // left source codes
   localparam int LS_A     = 1;
   localparam int LS_B     = 2;
   localparam int LS_IXL   = 3;
   localparam int LS_IXH   = 4;
   localparam int LS_PCL   = 5;
   localparam int LS_PCH   = 6;
   localparam int LS_SPL   = 7;
   localparam int LS_SPH   = 8;
   localparam int LS_STAT  = 9;
   localparam int LS_DBUS  = 10;
   localparam int LS_COUNT = 11;

   // right source codes
   localparam int RS_TMP   = 1;
   localparam int RS_DBUS  = 2;
   localparam int RS_COUNT = 3;

   // data-bus transceiver select codes
   localparam int DS_LEFT  = 1;
   localparam int DS_RIGHT = 2;
endpackage

// File: rtl/rfb_load_dec.sv
module rfb_load_dec #(
   parameter int SELW = 4,
   parameter int NOUT = 7
) (
   input  logic            en,
   input  logic [SELW-1:0] sel,
   output logic [NOUT-1:0] hot
);
   if (NOUT >= (1 << SELW)) begin : g_bad
      $error("rfb_load_dec: NOUT needs a free null code");
   end

   for (genvar i = 0; i < NOUT; i++) begin : g_line
      assign hot[i] = en && (sel == SELW'(i + 1));
   end
endmodule

// File: rtl/rfb_regs.sv
module rfb_regs #(
   parameter int DW   = 8,
   parameter int NREG = 7
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NREG-1:0]          we,
   input  logic [DW-1:0]            d,
   output logic [NREG-1:0][DW-1:0]  q
);
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DW-1:0] r;
      always_ff @(posedge clk) begin
         if (rst)
            r <= '0;
         else if (we[i])
            r <= d;
      end
      assign q[i] = r;
   end
endmodule

// File: rtl/rfb_src_mux.sv
module rfb_src_mux #(
   parameter int DW   = 8,
   parameter int SELW = 4,
   parameter int NSRC = 11
) (
   input  logic [SELW-1:0]          sel,
   input  logic [NSRC-1:0][DW-1:0]  src,
   output logic [DW-1:0]            bus
);
   if (NSRC > (1 << SELW)) begin : g_bad
      $error("rfb_src_mux: select field too narrow");
   end

   logic [NSRC-1:0][DW-1:0] gated;

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      if (g == 0) begin : g_null
         assign gated[g] = '0;
      end else begin : g_drv
         assign gated[g] = (sel == SELW'(g)) ? src[g] : '0;
      end
   end

   always_comb begin
      bus = '0;
      for (int k = 0; k < NSRC; k++)
         bus = bus | gated[k];
   end
endmodule

// File: rtl/rfb_xcvr_ctl.sv
module rfb_xcvr_ctl
   import rfb_pkg::*;
(
   input  logic [L_SEL_W-1:0] lsel,
   input  logic [R_SEL_W-1:0] rsel,
   input  logic [D_SEL_W-1:0] dsel,
   output logic               xl_en,
   output logic               xr_en,
   output logic               xl_in,
   output logic               xr_in,
   output logic               xl_drive,
   output logic               xr_drive,
   output logic               bus_err
);
   logic left_reads, right_reads, clash;

   always_comb begin
      left_reads  = (lsel == L_SEL_W'(LS_DBUS));
      right_reads = (rsel == R_SEL_W'(RS_DBUS));
      clash       = left_reads && right_reads;
      xl_in       = left_reads;
      xr_in       = right_reads;
      xl_en       = (dsel == D_SEL_W'(DS_LEFT))  && !clash;
      xr_en       = (dsel == D_SEL_W'(DS_RIGHT)) && !clash;
      xl_drive    = xl_en && !left_reads;
      xr_drive    = xr_en && !right_reads;
      bus_err     = clash;
   end
endmodule

// File: rtl/rf_busbank.sv
module rf_busbank
   import rfb_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load_en,
   input  logic [LD_SEL_W-1:0] load_sel,
   input  logic [DW-1:0]       alu_z,
   input  logic [L_SEL_W-1:0]  lsel,
   input  logic [R_SEL_W-1:0]  rsel,
   input  logic [D_SEL_W-1:0]  dsel,
   input  logic [DW-1:0]       pc_lo,
   input  logic [DW-1:0]       pc_hi,
   input  logic [DW-1:0]       stat_in,
   input  logic [DW-1:0]       dbus_in,
   output logic [DW-1:0]       left_bus,
   output logic [DW-1:0]       right_bus,
   output logic [DW-1:0]       dbus_out,
   output logic                dbus_oe,
   output logic                xl_en,
   output logic                xl_in,
   output logic                xr_en,
   output logic                xr_in,
   output logic                bus_err
);
   if (DW < 1) begin : g_bad_dw
      $error("rf_busbank: DW must be positive");
   end

   logic [NREG-1:0]              ld_hot;
   logic [NREG-1:0][DW-1:0]      reg_q;
   logic [LS_COUNT-1:0][DW-1:0]  lsrc;
   logic [RS_COUNT-1:0][DW-1:0]  rsrc;
   logic                         xl_drive, xr_drive;

   rfb_load_dec #(.SELW(LD_SEL_W), .NOUT(NREG)) i_dec (
      .en  (load_en),
      .sel (load_sel),
      .hot (ld_hot)
   );

   rfb_regs #(.DW(DW), .NREG(NREG)) i_regs (
      .clk (clk),
      .rst (rst),
      .we  (ld_hot),
      .d   (alu_z),
      .q   (reg_q)
   );

   rfb_xcvr_ctl i_xcvr (
      .lsel     (lsel),
      .rsel     (rsel),
      .dsel     (dsel),
      .xl_en    (xl_en),
      .xr_en    (xr_en),
      .xl_in    (xl_in),
      .xr_in    (xr_in),
      .xl_drive (xl_drive),
      .xr_drive (xr_drive),
      .bus_err  (bus_err)
   );

   always_comb begin
      lsrc           = '0;
      lsrc[LS_A]     = reg_q[RG_A];
      lsrc[LS_B]     = reg_q[RG_B];
      lsrc[LS_IXL]   = reg_q[RG_IXL];
      lsrc[LS_IXH]   = reg_q[RG_IXH];
      lsrc[LS_PCL]   = pc_lo;
      lsrc[LS_PCH]   = pc_hi;
      lsrc[LS_SPL]   = reg_q[RG_SPL];
      lsrc[LS_SPH]   = reg_q[RG_SPH];
      lsrc[LS_STAT]  = stat_in;
      lsrc[LS_DBUS]  = (xl_en && xl_in) ? dbus_in : '0;
   end

   always_comb begin
      rsrc           = '0;
      rsrc[RS_TMP]   = reg_q[RG_TMP];
      rsrc[RS_DBUS]  = (xr_en && xr_in) ? dbus_in : '0;
   end

   rfb_src_mux #(.DW(DW), .SELW(L_SEL_W), .NSRC(LS_COUNT)) i_lmux (
      .sel (lsel),
      .src (lsrc),
      .bus (left_bus)
   );

   rfb_src_mux #(.DW(DW), .SELW(R_SEL_W), .NSRC(RS_COUNT)) i_rmux (
      .sel (rsel),
      .src (rsrc),
      .bus (right_bus)
   );

   always_comb begin
      dbus_oe  = xl_drive || xr_drive;
      dbus_out = xl_drive ? left_bus : (xr_drive ? right_bus : '0);
   end
endmodule

// File: rtl/rfb_checker.sv
module rfb_checker
   import rfb_pkg::*;
#(
   parameter int DW = 8
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     load_en,
   input logic [LD_SEL_W-1:0]      load_sel,
   input logic [DW-1:0]            alu_z,
   input logic [L_SEL_W-1:0]       lsel,
   input logic [R_SEL_W-1:0]       rsel,
   input logic [DW-1:0]            left_bus,
   input logic [DW-1:0]            right_bus,
   input logic                     dbus_oe,
   input logic                     xl_en,
   input logic                     xr_en,
   input logic [NREG-1:0]          ld_hot,
   input logic [NREG-1:0][DW-1:0]  reg_q
);
   p_onehot_load_r1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ld_hot));

   for (genvar i = 0; i < NREG; i++) begin : g_slot
      p_capture_r1: assert property (@(posedge clk) disable iff (rst)
         (load_en && load_sel == LD_SEL_W'(i + 1)) |=> (reg_q[i] == $past(alu_z)));
      p_hold_r2: assert property (@(posedge clk) disable iff (rst)
         !(load_en && load_sel == LD_SEL_W'(i + 1)) |=> $stable(reg_q[i]));
   end

   p_reset_clear_r9: assert property (@(posedge clk)
      rst |=> (reg_q == '0));

   p_left_idle_r4: assert property (@(posedge clk) disable iff (rst)
      (lsel == '0 || lsel > L_SEL_W'(LS_DBUS)) |-> (left_bus == '0));

   p_right_idle_r5: assert property (@(posedge clk) disable iff (rst)
      (rsel == '0 || rsel == R_SEL_W'(3)) |-> (right_bus == '0));

   p_one_xcvr_r6: assert property (@(posedge clk) disable iff (rst)
      !(xl_en && xr_en));

   p_clash_r8: assert property (@(posedge clk) disable iff (rst)
      (lsel == L_SEL_W'(LS_DBUS) && rsel == R_SEL_W'(RS_DBUS))
         |-> (!xl_en && !xr_en && !dbus_oe && left_bus == '0 && right_bus == '0));
endmodule

bind rf_busbank rfb_checker #(.DW(DW)) i_rfb_checker (
   .clk       (clk),
   .rst       (rst),
   .load_en   (load_en),
   .load_sel  (load_sel),
   .alu_z     (alu_z),
   .lsel      (lsel),
   .rsel      (rsel),
   .left_bus  (left_bus),
   .right_bus (right_bus),
   .dbus_oe   (dbus_oe),
   .xl_en     (xl_en),
   .xr_en     (xr_en),
   .ld_hot    (ld_hot),
   .reg_q     (reg_q)
);

// File: tb/test_rf_busbank.sv
module test_rf_busbank;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       load_en = 1'b0;
   logic [3:0] load_sel = '0;
   logic [7:0] alu_z = '0;
   logic [3:0] lsel = '0;
   logic [1:0] rsel = '0;
   logic [1:0] dsel = '0;
   logic [7:0] pc_lo = 8'h51;
   logic [7:0] pc_hi = 8'hA2;
   logic [7:0] stat_in = 8'h3C;
   logic [7:0] dbus_in = 8'hE7;
   logic [7:0] left_bus, right_bus, dbus_out;
   logic       dbus_oe, xl_en, xl_in, xr_en, xr_in, bus_err;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   logic [7:0] m [7];

   always #10 clk = ~clk;

   rf_busbank #(.DW(8)) i_rf_busbank (
      .clk(clk), .rst(rst), .load_en(load_en), .load_sel(load_sel), .alu_z(alu_z),
      .lsel(lsel), .rsel(rsel), .dsel(dsel), .pc_lo(pc_lo), .pc_hi(pc_hi),
      .stat_in(stat_in), .dbus_in(dbus_in), .left_bus(left_bus), .right_bus(right_bus),
      .dbus_out(dbus_out), .dbus_oe(dbus_oe), .xl_en(xl_en), .xl_in(xl_in),
      .xr_en(xr_en), .xr_in(xr_in), .bus_err(bus_err)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (lsel=%0d rsel=%0d dsel=%0d)",
                  tag, act, exp, lsel, rsel, dsel);
      end
   endtask

   // model of one select combination, from the requirements
   task automatic sweep(input string phase);
      for (int l = 0; l < 16; l++) begin
         for (int r = 0; r < 4; r++) begin
            for (int d = 0; d < 4; d++) begin
               logic clash, el, er, il, ir, dl, dr;
               logic [7:0] el_bus, er_bus, edo;
               @(negedge clk);
               lsel = 4'(l); rsel = 2'(r); dsel = 2'(d);
               clash = (l == 10) && (r == 2);
               il = (l == 10);
               ir = (r == 2);
               el = (d == 1) && !clash;
               er = (d == 2) && !clash;
               case (l)
                  1: el_bus = m[0];
                  2: el_bus = m[1];
                  3: el_bus = m[2];
                  4: el_bus = m[3];
                  5: el_bus = pc_lo;
                  6: el_bus = pc_hi;
                  7: el_bus = m[4];
                  8: el_bus = m[5];
                  9: el_bus = stat_in;
                  10: el_bus = el ? dbus_in : 8'h00;
                  default: el_bus = 8'h00;
               endcase
               case (r)
                  1: er_bus = m[6];
                  2: er_bus = er ? dbus_in : 8'h00;
                  default: er_bus = 8'h00;
               endcase
               dl = el && !il;
               dr = er && !ir;
               edo = dl ? el_bus : (dr ? er_bus : 8'h00);
               #5;
               if (l == 0 || l > 10)
                  chk({phase, " R4 left idle"}, 16'(left_bus), 16'(el_bus));
               else
                  chk({phase, " R3 left source"}, 16'(left_bus), 16'(el_bus));
               chk({phase, " R5 right source"}, 16'(right_bus), 16'(er_bus));
               chk({phase, " R6 transceiver enables"}, 16'({xl_en, xr_en}), 16'({el, er}));
               chk({phase, " R7 directions"}, 16'({xl_in, xr_in}), 16'({il, ir}));
               chk({phase, " R7 data bus drive"}, 16'({dbus_oe, dbus_out}), 16'({dl | dr, edo}));
               chk({phase, " R8 conflict flag"}, 16'(bus_err), 16'(clash));
            end
         end
      end
   endtask

   task automatic load(input logic en, input logic [3:0] code, input logic [7:0] v);
      @(negedge clk);
      load_en = en; load_sel = code; alu_z = v;
      @(negedge clk);
      load_en = 1'b0; load_sel = '0; alu_z = '0;
   endtask

   initial begin
      for (int i = 0; i < 7; i++) m[i] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      sweep("R9 after reset");

      // R1: distinct value into every register
      for (int k = 1; k <= 7; k++) begin
         logic [7:0] v;
         v = 8'((k * 37 + 5) ^ 8'h80);
         load(1'b1, 4'(k), v);
         m[k-1] = v;
         @(negedge clk);
         lsel = (k == 7) ? 4'd0 : ((k <= 4) ? 4'(k) : 4'(k + 2));
         rsel = (k == 7) ? 2'd1 : 2'd0;
         dsel = 2'd0;
         #5;
         chk("R1 write visible next cycle",
             16'((k == 7) ? right_bus : left_bus), 16'(v));
      end
      sweep("R1 after writes");

      // R2: codes without a register, and strobe low
      load(1'b1, 4'd0, 8'hFF);
      for (int k = 8; k < 16; k++) load(1'b1, 4'(k), 8'hFF);
      for (int k = 1; k <= 7; k++) load(1'b0, 4'(k), 8'hAA);
      pc_lo = 8'h0F; pc_hi = 8'hF0; stat_in = 8'h99; dbus_in = 8'h5A;
      sweep("R2 ignored loads");

      // R9: reset wins over a simultaneous load
      @(negedge clk);
      rst = 1'b1; load_en = 1'b1; load_sel = 4'd1; alu_z = 8'hC3;
      @(negedge clk);
      rst = 1'b0; load_en = 1'b0; load_sel = '0; alu_z = '0;
      for (int i = 0; i < 7; i++) m[i] = 8'h00;
      sweep("R9 reset over load");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule